// File: doc/BRIEF.md
# Decimating Symmetric FIR Filter

This block is a direct-form FIR filter that also lowers the sample rate by an integer factor. It sits after a CIC decimator in a down-conversion chain, either as the stage that corrects the CIC pass-band droop or as the last stage that shapes the channel. Samples arrive as a signed stream with a valid strobe. Each accepted sample enters a tap delay line. A convolution is formed only for one sample in every `DECIM` accepted samples, so the outputs that the decimator would discard are never computed.

The tap count, the decimation factor, the coefficient scale and the output scaling are parameters. The coefficients are constants built inside the block and follow a symmetric triangular profile. The symmetry lets the filter add the two mirrored taps before it multiplies, so it needs only half as many multipliers. The same module builds the 11-tap droop-compensation configuration (decimating by 2 or 4) and the 41-tap final-stage configuration (decimating by 2).

A two-state phase controller tracks the decimation phase. In `PH_GATHER` it counts accepted samples that do not produce an output. When the count reaches `DECIM-2` and one more sample is accepted, it takes the transition *arm* to `PH_FIRE`. In `PH_FIRE` the next accepted sample starts a computation, and the controller takes the transition *fire* back to `PH_GATHER` with the count cleared. A sample is accepted only when `in_valid` is high. Without an accepted sample, both states hold. The computation runs through three register stages: symmetric pre-add with multiply, adder tree, and round with saturate.

Top module: `fir_decim_sym`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0, and samples presented with `in_valid` high are not accepted.
- R2: A sample is accepted at a rising edge where `in_valid` is 1, and it becomes the newest tap. When `in_valid` is 0, the delay line and the decimation phase stay unchanged.
- R3: `out_valid` is a one-cycle pulse. It is produced exactly once per `DECIM` accepted samples, for the accepted samples numbered `DECIM`, `2*DECIM`, ... counted since reset.
- R4: The result for a triggering sample presented in clock cycle c is on the outputs in cycle c+4.
- R5: The pre-rounding value is acc = Σ b_i·x[n−i] for i = 0 to NTAPS−1. Here x[n] is the triggering sample, x[n−i] is the sample accepted i samples earlier, and b_i = (min(i, NTAPS−1−i)+1)·COEF_STEP.
- R6: Rounding is to nearest, with ties toward positive infinity: out = floor((acc + 2^(OUT_SHIFT−1)) / 2^OUT_SHIFT).
- R7: A rounded value outside the signed `OUT_W` range is clamped to −2^(OUT_W−1) or 2^(OUT_W−1)−1.
- R8: `out_data` holds its last value while `out_valid` is 0.
- R9: Reset empties the history. After reset, taps not yet filled count as zero in R5.
- R10: The same module configured with NTAPS=41, DECIM=2 and OUT_SHIFT=14 meets R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking `in_data` as a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new filtered sample |
| out_data | output | OUT_W | Signed, rounded and saturated filter output |

## Verification
The bound checker checks on every cycle:
- the shape of the output pulse;
- the fixed four-cycle gap between a triggering sample and its result, in both directions;
- that `out_data` holds between pulses;
- that an idle strobe leaves the delay line unchanged, while a valid one loads the new sample at the head.

The numerical content can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. These scenarios cover:
- impulse responses that expose each coefficient;
- rounding of ties on small signed inputs;
- saturation at both rails;
- strobes with gaps;
- zero history after a reset in the middle of a run.

// File: rtl/fir_decim_pkg.sv
`timescale 1ns/1ps
package fir_decim_pkg;

    // Decimation phase controller states
    typedef enum logic [0:0] {
        PH_GATHER = 1'b0,
        PH_FIRE   = 1'b1
    } phase_state_e;

    // Symmetric triangular coefficient: outer taps smallest, centre largest
    function automatic longint tri_coef(input int idx, input int ntaps, input int step);
        int mirror;
        int rank;
        mirror = ntaps - 1 - idx;
        rank   = (idx < mirror) ? idx : mirror;
        return longint'(rank + 1) * longint'(step);
    endfunction

endpackage

// File: rtl/fir_phase_ctl.sv
`timescale 1ns/1ps
module fir_phase_ctl
    import fir_decim_pkg::*;
#(
    parameter int DECIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic fire
);

    localparam int CW = (DECIM > 2) ? $clog2(DECIM) : 1;
    localparam logic [CW-1:0] LAST_GATHER = CW'(DECIM - 2);

    phase_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_GATHER;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: arm (GATHER->FIRE), fire (FIRE->GATHER)
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_GATHER: begin
                if (in_valid) begin
                    if (cnt_q == LAST_GATHER) begin
                        state_d = PH_FIRE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_FIRE: begin
                if (in_valid) begin
                    state_d = PH_GATHER;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PH_GATHER;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fire = (state_q == PH_FIRE) && in_valid;
    end

endmodule

// File: rtl/fir_tapline.sv
`timescale 1ns/1ps
module fir_tapline #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [DATA_W-1:0]       din,
    output logic [NTAPS*DATA_W-1:0] taps
);

    // taps slice 0 is the newest sample
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        logic [DATA_W-1:0] prev_w;
        logic [DATA_W-1:0] stage_q;

        if (t == 0) begin : g_head
            assign prev_w = din;
        end else begin : g_body
            assign prev_w = taps[(t-1)*DATA_W +: DATA_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if (shift_en) begin
                stage_q <= prev_w;
            end
        end

        assign taps[t*DATA_W +: DATA_W] = stage_q;
    end

endmodule

// File: rtl/fir_mac_pipe.sv
`timescale 1ns/1ps
module fir_mac_pipe
    import fir_decim_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 24,
    parameter int NTAPS     = 11,
    parameter int COEF_STEP = 1024,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [NTAPS*DATA_W-1:0] taps,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    localparam int NHALF  = (NTAPS + 1) / 2;
    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS);

    localparam logic signed [ACC_W:0] RND_HALF = (ACC_W+1)'(64'sd1 <<< (OUT_SHIFT - 1));
    localparam logic signed [ACC_W:0] OMAX     = (ACC_W+1)'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W:0] OMIN     = ~OMAX;

    // Constant coefficient array (first half; the rest mirrors it)
    logic signed [COEF_W-1:0] coef_w [NHALF];
    for (genvar k = 0; k < NHALF; k++) begin : g_coef
        assign coef_w[k] = COEF_W'(tri_coef(k, NTAPS, COEF_STEP));
    end

    logic                     fire_q, v1_q, v2_q;
    logic signed [PRE_W-1:0]  pre_w  [NHALF];
    logic signed [PROD_W-1:0] prod_q [NHALF];
    logic signed [ACC_W-1:0]  acc_w, sum_q;
    logic signed [ACC_W:0]    rnd_w, quo_w;

    // Symmetric pre-add of mirrored taps
    always_comb begin
        for (int k = 0; k < NHALF; k++) begin
            if (k == NTAPS - 1 - k) begin
                pre_w[k] = PRE_W'($signed(taps[k*DATA_W +: DATA_W]));
            end else begin
                pre_w[k] = PRE_W'($signed(taps[k*DATA_W +: DATA_W]))
                         + PRE_W'($signed(taps[(NTAPS-1-k)*DATA_W +: DATA_W]));
            end
        end
    end

    // Stage 0 (fire capture) and stage 1 (products)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            v1_q   <= 1'b0;
            for (int k = 0; k < NHALF; k++) prod_q[k] <= '0;
        end else begin
            fire_q <= fire;
            v1_q   <= fire_q;
            if (fire_q) begin
                for (int k = 0; k < NHALF; k++) begin
                    prod_q[k] <= PROD_W'(pre_w[k]) * PROD_W'(coef_w[k]);
                end
            end
        end
    end

    // Adder tree
    always_comb begin
        acc_w = '0;
        for (int k = 0; k < NHALF; k++) acc_w = acc_w + ACC_W'(prod_q[k]);
    end

    // Stage 2: sum register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            v2_q  <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) sum_q <= acc_w;
        end
    end

    // Round to nearest, ties upward
    always_comb begin
        rnd_w = (ACC_W+1)'(sum_q) + RND_HALF;
        quo_w = rnd_w >>> OUT_SHIFT;
    end

    // Stage 3: saturate and register output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v2_q;
            if (v2_q) begin
                if (quo_w > OMAX)      out_data <= OMAX[OUT_W-1:0];
                else if (quo_w < OMIN) out_data <= OMIN[OUT_W-1:0];
                else                   out_data <= quo_w[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fir_decim_sym.sv
`timescale 1ns/1ps
module fir_decim_sym #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 24,
    parameter int NTAPS     = 11,
    parameter int DECIM     = 4,
    parameter int COEF_STEP = 1024,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);

    logic                    fire;
    logic [NTAPS*DATA_W-1:0] taps;

    fir_phase_ctl #(
        .DECIM (DECIM)
    ) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .fire     (fire)
    );

    fir_tapline #(
        .DATA_W (DATA_W),
        .NTAPS  (NTAPS)
    ) line_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (in_data),
        .taps     (taps)
    );

    fir_mac_pipe #(
        .DATA_W    (DATA_W),
        .COEF_W    (COEF_W),
        .NTAPS     (NTAPS),
        .COEF_STEP (COEF_STEP),
        .OUT_W     (OUT_W),
        .OUT_SHIFT (OUT_SHIFT)
    ) mac_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .taps      (taps),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fir_decim_sym_chk.sv
`timescale 1ns/1ps
module fir_decim_sym_chk #(
    parameter int DATA_W = 16,
    parameter int NTAPS  = 11,
    parameter int DECIM  = 4,
    parameter int OUT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [DATA_W-1:0]       in_data,
    input logic                    out_valid,
    input logic [OUT_W-1:0]        out_data,
    input logic [NTAPS*DATA_W-1:0] taps
);

    localparam int KW = $clog2(DECIM + 1);

    // Independent count of accepted samples modulo DECIM
    logic [KW-1:0] seen_q;
    logic          trig_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid) begin
            seen_q <= (seen_q == KW'(DECIM - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    assign trig_w = in_valid && (seen_q == KW'(DECIM - 1));

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                   // R3

    AST_TRIG_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        trig_w |=> ##3 out_valid);                                   // R4

    AST_OUT_HAS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(trig_w, 4));                             // R3

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));                           // R8

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(taps));                                // R2

    AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taps[DATA_W-1:0] == $past(in_data)));          // R2

endmodule

bind fir_decim_sym fir_decim_sym_chk #(
    .DATA_W (DATA_W),
    .NTAPS  (NTAPS),
    .DECIM  (DECIM),
    .OUT_W  (OUT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .taps      (taps)
);

// File: tb/fir_decim_sym_tb_top.sv
`timescale 1ns/1ps
module fir_decim_sym_tb_top;

    localparam int STEP = 1024;
    localparam int NT [2] = '{11, 41};
    localparam int DC [2] = '{4, 2};
    localparam int SH [2] = '{12, 14};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic ov [2];
    logic signed [15:0] od [2];

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    longint hist [2][64];
    int     cnt [2];
    bit     pv [2][4];
    longint pd [2][4];
    longint lastv [2];
    int unsigned seed = 32'h1234_5678;

    always #5ns clk = ~clk;

    fir_decim_sym #(.NTAPS(11), .DECIM(4), .OUT_SHIFT(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[0]), .out_data(od[0]));

    fir_decim_sym #(.NTAPS(41), .DECIM(2), .OUT_SHIFT(14)) dut41_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov[1]), .out_data(od[1]));

    function automatic int unsigned rnd32();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Behavioural reference: R5 sum, R6 rounding, R7 clamp
    function automatic longint model_out(int id);
        longint acc = 0;
        longint q;
        for (int i = 0; i < NT[id]; i++) begin
            int r = (i < NT[id] - 1 - i) ? i : NT[id] - 1 - i;
            acc += longint'(r + 1) * STEP * hist[id][i];
        end
        q = (acc + (64'sd1 <<< (SH[id] - 1))) >>> SH[id];
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    function automatic void model_clear();
        for (int id = 0; id < 2; id++) begin
            for (int i = 0; i < 64; i++) hist[id][i] = 0;
            for (int s = 0; s < 4; s++) begin pv[id][s] = 0; pd[id][s] = 0; end
            cnt[id] = 0;
            lastv[id] = 0;
        end
    endfunction

    task automatic step(input bit v, input longint d, input bit rst_lvl);
        @(negedge clk);
        for (int id = 0; id < 2; id++) begin
            longint got = longint'(od[id]);
            string tag = (id == 1) ? " R10" : "";
            n_chk++;
            if (pv[id][0]) begin
                if (ov[id] !== 1'b1) begin
                    n_fail++;
                    $display("FAIL %s R3 R4%s inst=%0d out_valid got %0d exp 1", cur_req, tag, id, ov[id]);
                end else if (got != pd[id][0]) begin
                    n_fail++;
                    $display("FAIL %s R5%s inst=%0d out_data got %0d exp %0d", cur_req, tag, id, got, pd[id][0]);
                end
                lastv[id] = pd[id][0];
            end else begin
                if (ov[id] !== 1'b0) begin
                    n_fail++;
                    $display("FAIL %s R3 R4%s inst=%0d out_valid got %0d exp 0", cur_req, tag, id, ov[id]);
                end else if (got != lastv[id]) begin
                    n_fail++;
                    $display("FAIL %s R8%s inst=%0d held out_data got %0d exp %0d", cur_req, tag, id, got, lastv[id]);
                end
            end
            for (int s = 0; s < 3; s++) begin pv[id][s] = pv[id][s+1]; pd[id][s] = pd[id][s+1]; end
            pv[id][3] = 0;
        end
        rst_n    = rst_lvl;
        in_valid = v;
        in_data  = 16'(d);
        if (!rst_lvl) begin
            model_clear();
        end else if (v) begin
            for (int id = 0; id < 2; id++) begin
                for (int i = 63; i > 0; i--) hist[id][i] = hist[id][i-1];
                hist[id][0] = longint'($signed(16'(d)));
                cnt[id]++;
                if (cnt[id] == DC[id]) begin
                    cnt[id] = 0;
                    pv[id][3] = 1;
                    pd[id][3] = model_out(id);
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, got running exp finished");
        finish_run();
    end

    initial begin
        model_clear();
        // R1: reset holds outputs at zero and ignores strobes
        cur_req = "R1";
        for (int i = 0; i < 5; i++) step(1'b1, 30000, 1'b0);
        // R5/R9: impulse into zero history exposes each coefficient
        cur_req = "R9";
        step(1'b1, 8000, 1'b1);
        cur_req = "R5";
        for (int i = 0; i < 50; i++) step(1'b1, 0, 1'b1);
        // R2: random data with gaps in the strobe
        cur_req = "R2";
        for (int i = 0; i < 200; i++) begin
            int unsigned r = rnd32();
            step(r[0] | r[1], longint'($signed(r[31:16])) / 4, 1'b1);
        end
        // R7: saturation at both rails
        cur_req = "R7";
        for (int i = 0; i < 50; i++) step(1'b1, 32767, 1'b1);
        for (int i = 0; i < 50; i++) step(1'b1, -32768, 1'b1);
        // R6: small signed values hit rounding ties
        cur_req = "R6";
        for (int i = 0; i < 120; i++) begin
            int unsigned r = rnd32();
            step(r[5], longint'($signed(r[3:0])), 1'b1);
        end
        // R9: reset mid-run, history must restart from zero
        cur_req = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, -20000, 1'b0);
        cur_req = "R9";
        for (int i = 0; i < 3; i++) step(1'b1, 12345, 1'b1);
        for (int i = 0; i < 50; i++) step(i[0], 0, 1'b1);
        cur_req = "R8";
        for (int i = 0; i < 8; i++) step(1'b0, 999, 1'b1);
        finish_run();
    end

endmodule